// File: doc/BRIEF.md
# Byte Prefetch Instruction Queue

This block keeps a short run of instruction bytes ready in front of an execution unit. It reads code from a 16-bit memory bus one word at a time and hands the bytes out one at a time, oldest first. A word fetch is started only when the queue has space for both bytes of a word and the execution unit has not claimed the bus for an operand access. At most one fetch is outstanding at any time.

After a taken branch, call or return, the execution unit asserts a flush together with the new code address. The flush drops every buffered byte and abandons any fetch still in flight, and fetching restarts at the new address. If that address is odd, the first word fetched supplies only its upper byte, and every later fetch is word aligned. The memory side answers a request with a one-cycle `fetch_done_i` pulse carrying the addressed word. The pulse counts only while `fetch_req_o` is high.

Top module: `prefetch_queue`

## Requirements
- R1: The byte count `count_o` never exceeds the queue depth (6 bytes by default).
- R2: `fetch_req_o` rises only after a clock edge at which the count was at most depth minus two, `operand_req_i` was low and `flush_i` was low. With 5 bytes held, or with `operand_req_i` high, no new fetch starts.
- R3: A completed fetch at an even address adds two bytes to the queue. `fetch_data_i[7:0]` is queued first and `fetch_data_i[15:8]` second.
- R4: Bytes leave in the order they arrived. `byte_o` always shows the oldest byte, and each accepted `pop_i` removes exactly one byte.
- R5: `fetch_addr_o` is the byte address of the next code byte to fetch. It advances by the number of bytes each completed fetch delivered, so fetching walks the code stream in order.
- R6: After reset, and on the cycle after `flush_i`, the count is 0, `valid_o` is low and `fetch_req_o` is low. After a flush the next fetch address equals `flush_addr_i`.
- R7: When the fetch address is odd, a completed fetch queues only `fetch_data_i[15:8]` and raises the count by one. The following fetch address is even.
- R8: `valid_o` is high exactly when the count is nonzero. A `pop_i` while the queue is empty is ignored, and the count stays 0.
- R9: A pop and a completed fetch in the same cycle give a new count equal to the old count minus one plus the bytes delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard queue contents and restart fetching |
| flush_addr_i | input | ADDR_W | Restart byte address, taken with `flush_i` |
| operand_req_i | input | 1 | Execution unit wants the bus for an operand; blocks new fetches |
| fetch_req_o | output | 1 | A word fetch is outstanding |
| fetch_addr_o | output | ADDR_W | Byte address of the next code byte; memory returns the word that contains it |
| fetch_done_i | input | 1 | Fetch completed this cycle; counts only while `fetch_req_o` is high |
| fetch_data_i | input | 16 | Fetched word; the low byte is at the even address |
| pop_i | input | 1 | Consumer takes the byte on `byte_o` |
| byte_o | output | 8 | Oldest queued byte |
| valid_o | output | 1 | `byte_o` holds a queued byte |
| count_o | output | CNT_W | Number of bytes held |

## Verification
Some properties are checked on every cycle: the count bound, the admission conditions for a new fetch, the empty state after a flush, the limits on how far the count can move in one cycle, that a pop on an empty queue changes nothing, and the word alignment after a completed fetch. Other behaviour only the bench scenarios can show. This covers the byte order through the queue, the exact byte values taken from each half of the bus word, the fetch address walk after an odd restart, and a flush that abandons a stalled fetch. It also covers pops that overlap pushes and the steady fill levels of 6 and 5 bytes.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_e;
endpackage

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 6,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              operand_req_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              fetch_done_i,
  input  logic [15:0]       fetch_data_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output push_e             push_n_o,
  output logic [7:0]        push_b0_o,
  output logic [7:0]        push_b1_o
);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - 2);

  logic              pending_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              room;

  assign accept = pending_q & fetch_done_i & ~flush_i;
  assign room   = count_i <= ROOM_MAX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      addr_q    <= '0;
    end else if (flush_i) begin
      pending_q <= 1'b0;
      addr_q    <= flush_addr_i;
    end else if (accept) begin
      pending_q <= 1'b0;
      addr_q    <= addr_q + (addr_q[0] ? ADDR_W'(1) : ADDR_W'(2));
    end else if (!pending_q && room && !operand_req_i) begin
      pending_q <= 1'b1;
    end
  end

  // odd address: only the upper half of the word belongs to the stream
  assign push_n_o     = !accept ? PUSH_NONE : (addr_q[0] ? PUSH_ONE : PUSH_TWO);
  assign push_b0_o    = addr_q[0] ? fetch_data_i[15:8] : fetch_data_i[7:0];
  assign push_b1_o    = fetch_data_i[15:8];
  assign fetch_req_o  = pending_q;
  assign fetch_addr_o = addr_q;

  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_q) |-> ($past(count_i) <= ROOM_MAX) && !$past(operand_req_i) && !$past(flush_i)); // R2
  AST_ALIGN_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !addr_q[0]); // R7
endmodule

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             pop_i,
  input  push_e            push_n_i,
  input  logic [7:0]       push_b0_i,
  input  logic [7:0]       push_b1_i,
  output logic [7:0]       head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [7:0]       slot_q [DEPTH];
  logic [7:0]       slot_d [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] base;
  logic             pop_ok;
  logic             wr0;
  logic             wr1;

  assign pop_ok = pop_i & (count_q != '0);
  assign base   = count_q - CNT_W'(pop_ok);
  assign wr0    = push_n_i != PUSH_NONE;
  assign wr1    = push_n_i == PUSH_TWO;

  // shift toward slot 0 on pop, write new bytes just past the survivors
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [7:0] shifted;
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = pop_ok ? slot_q[i+1] : slot_q[i];
    end else begin : g_last
      assign shifted = pop_ok ? 8'h00 : slot_q[i];
    end
    assign slot_d[i] = (wr1 && (base + CNT_W'(1)) == CNT_W'(i)) ? push_b1_i :
                       (wr0 && base == CNT_W'(i))               ? push_b0_i : shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= 8'h00;
    end else if (flush_i) begin
      count_q <= '0;
    end else begin
      count_q <= base + CNT_W'(push_n_i);
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign head_o  = slot_q[0];
  assign count_o = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= DEPTH); // R1
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0) && (push_n_i == PUSH_NONE) && !flush_i |=> count_q == '0); // R8
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (int'(count_q) <= int'($past(count_q)) + 2) &&
                 (int'(count_q) + 1 >= int'($past(count_q)))); // R9
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 6,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              operand_req_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_done_i,
  input  logic [15:0]       fetch_data_i,
  input  logic              pop_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  count_o
);
  push_e            push_n;
  logic [7:0]       push_b0;
  logic [7:0]       push_b1;
  logic [CNT_W-1:0] count;

  pfq_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .flush_addr_i  (flush_addr_i),
    .operand_req_i (operand_req_i),
    .count_i       (count),
    .fetch_done_i  (fetch_done_i),
    .fetch_data_i  (fetch_data_i),
    .fetch_req_o   (fetch_req_o),
    .fetch_addr_o  (fetch_addr_o),
    .push_n_o      (push_n),
    .push_b0_o     (push_b0),
    .push_b1_o     (push_b1)
  );

  pfq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .pop_i     (pop_i),
    .push_n_i  (push_n),
    .push_b0_i (push_b0),
    .push_b1_i (push_b1),
    .head_o    (byte_o),
    .count_o   (count)
  );

  assign count_o = count;
  assign valid_o = count != '0;

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0) && !fetch_req_o && (fetch_addr_o == $past(flush_addr_i))); // R6
endmodule

// File: tb/test_prefetch_queue.sv
module test_prefetch_queue;
  localparam int DEPTH  = 6;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              flush = 1'b0;
  logic [ADDR_W-1:0] flush_addr = '0;
  logic              op_req = 1'b0;
  logic              done = 1'b0;
  logic [15:0]       data = '0;
  logic              pop = 1'b0;
  wire               req;
  wire  [ADDR_W-1:0] faddr;
  wire  [7:0]        byte_q;
  wire               valid;
  wire  [CNT_W-1:0]  cnt;

  prefetch_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_prefetch_queue (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .flush_addr_i(flush_addr),
    .operand_req_i(op_req), .fetch_req_o(req), .fetch_addr_o(faddr),
    .fetch_done_i(done), .fetch_data_i(data), .pop_i(pop),
    .byte_o(byte_q), .valid_o(valid), .count_o(cnt)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]        sb[$];
  bit                pop_en = 1'b0, pop_force = 1'b0, mem_stall = 1'b0, flush_req = 1'b0;
  logic [ADDR_W-1:0] flush_tgt = '0, exp_addr = '0;
  int                lat = 0;
  int                overlap = 0;
  logic              pre_req = 1'b0, pre_op = 1'b0, pre_flush = 1'b0;
  logic [CNT_W-1:0]  pre_cnt = '0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] mb(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
  endfunction

  // values seen by the design at each edge
  always @(posedge clk) begin
    pre_req   <= req;
    pre_cnt   <= cnt;
    pre_op    <= op_req;
    pre_flush <= flush;
  end

  // driver (memory model, flush, pop) and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(cnt) == sb.size(), "R9", "byte count", int'(cnt), sb.size());
      chk(valid == (cnt != '0), "R8", "valid flag", valid, cnt != '0);
      chk(int'(cnt) <= DEPTH, "R1", "count bound", int'(cnt), DEPTH);
      if (req && !pre_req)
        chk(int'(pre_cnt) <= DEPTH - 2 && !pre_op && !pre_flush, "R2", "fetch start gate",
            int'(pre_cnt), DEPTH - 2);
      done = 1'b0;
      pop = 1'b0;
      flush = 1'b0;
      if (flush_req) begin
        flush = 1'b1;
        flush_addr = flush_tgt;
        flush_req = 1'b0;
        sb.delete();
        exp_addr = flush_tgt;
        lat = 0;
      end else begin
        if ((pop_en && valid) || pop_force) begin
          pop = 1'b1;
          if (valid) begin
            chk(sb.size() > 0 && byte_q == sb[0], "R4", "head byte", byte_q,
                sb.size() > 0 ? int'(sb[0]) : -1);
            if (sb.size() > 0) void'(sb.pop_front());
          end
        end
        if (req) begin
          chk(faddr == exp_addr, "R5", "fetch address", int'(faddr), int'(exp_addr));
          if (!mem_stall && lat >= 1) begin
            logic [ADDR_W-1:0] a0;
            a0 = {exp_addr[ADDR_W-1:1], 1'b0};
            done = 1'b1;
            data = {mb(a0 + ADDR_W'(1)), mb(a0)};
            if (exp_addr[0]) begin
              sb.push_back(mb(exp_addr));
              exp_addr = exp_addr + ADDR_W'(1);
            end else begin
              sb.push_back(mb(a0));
              sb.push_back(mb(a0 + ADDR_W'(1)));
              exp_addr = exp_addr + ADDR_W'(2);
            end
            if (pop && valid) overlap++;
            lat = 0;
          end else lat++;
        end else lat = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_flush(input logic [ADDR_W-1:0] a);
    flush_tgt = a;
    flush_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    chk(cnt == '0 && !valid && !req, "R6", "empty after flush", int'(cnt), 0);
  endtask

  task automatic wait_data();
    for (int k = 0; k < 50 && cnt == '0; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(cnt == '0 && !valid && !req, "R6", "reset state", int'(cnt), 0);
    rst_n = 1'b1;
    step(1);

    // fill from an even address with no consumer
    do_flush(20'h00100);
    wait_data();
    chk(cnt == CNT_W'(2), "R3", "first word adds two", int'(cnt), 2);
    step(20);
    chk(cnt == CNT_W'(DEPTH) && !req, "R1", "full queue, no fetch", int'(cnt), DEPTH);

    // drain and refill together
    pop_en = 1'b1;
    step(60);
    chk(overlap > 0, "R9", "pop overlapped push", overlap, 1);

    // operand traffic blocks fetching
    op_req = 1'b1;
    step(30);
    chk(cnt == '0 && !req, "R2", "operand use blocks fetch", int'(cnt), 0);

    // pops on an empty queue
    pop_en = 1'b0;
    pop_force = 1'b1;
    step(5);
    chk(cnt == '0 && !valid, "R8", "empty pop ignored", int'(cnt), 0);
    pop_force = 1'b0;
    op_req = 1'b0;
    pop_en = 1'b1;
    step(40);

    // flush a stalled fetch, restart odd
    pop_en = 1'b0;
    mem_stall = 1'b1;
    do_flush(20'h0A000);
    step(4);
    chk(req == 1'b1, "R2", "fetch held outstanding", req, 1);
    mem_stall = 1'b0;
    mem_stall = 1'b1;
    do_flush(20'h2468B);
    mem_stall = 1'b0;
    wait_data();
    chk(cnt == CNT_W'(1), "R7", "odd restart adds one", int'(cnt), 1);
    chk(faddr[0] == 1'b0, "R7", "aligned after odd", int'(faddr), int'(faddr & ~20'h1));
    step(20);
    chk(cnt == CNT_W'(5) && !req, "R2", "one free slot, no fetch", int'(cnt), 5);

    // flush a populated queue across the top of the address space
    pop_en = 1'b1;
    step(10);
    pop_en = 1'b0;
    step(10);
    do_flush(20'hFFFFD);
    pop_en = 1'b1;
    step(40);
    chk(exp_addr < 20'h00100, "R5", "address wrapped in order", int'(exp_addr), 0);

    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule